// File: doc/BRIEF.md
# Serial-Access Binary Time Counter

This block keeps a free-running 40-bit time value: a 32-bit count of whole seconds in the upper bits and an 8-bit count of 1/256-second steps in the lower bits. A 32.768 kHz reference is divided by 128 to give the 256 Hz step. Software reaches the counter through a four-wire serial port (chip select, serial clock, data in, data out) in clock mode 0. Every access opens with a command byte and is followed by a fixed-length data burst.

A read captures the whole count into a holding register when its command byte ends, and then shifts out that frozen copy. A steady tick during the transfer therefore cannot corrupt the returned value. A write reaches the counter only if its full 40-bit burst arrives and writing has been enabled beforehand through a separate access to the control byte. A burst that is cut short leaves the count as it was. The serial inputs and the reference clock are sampled by a fast system clock through two-flop synchronizers, so all state lives in one clock domain.

The serial engine is a state machine with these states:
- ST_IDLE: chip select high. It goes to ST_CMD when chip select falls.
- ST_CMD: collects eight command bits. On the eighth bit it branches to ST_WR_TIME, ST_WR_CTRL, ST_RD_TIME or ST_RD_CTRL, or to ST_SKIP for an unknown address.
- Each data state: goes to ST_SKIP after its last bit (40 bits for time, 8 bits for control).
- ST_SKIP: ignores everything until chip select rises.
- Any state: returns to ST_IDLE when chip select rises.

Top module: `rtc_serial_timer`

## Requirements
- R1: After reset, the count is 0, the control byte reads 0 and data out is 0.
- R2: While the run bit is 1, the fraction field advances by exactly one on every 128th rising edge of the reference clock, counted by a 7-bit prescaler.
- R3: When the fraction field steps from FFh it becomes 00h and the seconds field increments. An all-ones 40-bit count wraps to zero.
- R4: While the run bit is 0, the count and the prescaler hold regardless of reference edges.
- R5: The command byte is sent MSB first. Bit 7 = 1 means read and 0 means write; bits 6:0 are the address. Address 01h is the 40-bit time value and address 02h is the control byte (bit 0 = run, bit 1 = write enable, other bits read 0). Accesses to any other address change nothing, and their read data is all zeros.
- R6: A time write sends 40 bits MSB first: seconds bit 31 first, fraction bit 0 last. The value is loaded when the 40th data bit is sampled, provided write enable is 1. The load also clears the prescaler.
- R7: A complete time write while write enable is 0 is discarded.
- R8: A time write whose chip select rises before the 40th data bit leaves the count unchanged.
- R9: A time read returns, MSB first, the count as it stood when the command byte completed, even if the counter ticks during the burst. Data out changes after falling serial-clock edges and is 0 while chip select is high.
- R10: A read ended early by raising chip select has valid leading bits, and the next access behaves normally.
- R11: Serial accesses never pause the counter: ticks that occur during a read are reflected in the next read.
- R12: A control read returns the run and write-enable bits last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | 32.768 kHz reference, asynchronous |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |

## Verification
Two events can meet in the same cycle: a prescaler tick, and either a snapshot capture or a load.

The snapshot case is provoked by leaving the prescaler one edge short of a tick that carries out of the fraction field, then delivering that edge while a read burst is shifting. The read must return the pre-tick value, and a follow-up read must show the increment.

For the load case, a checker property requires that the loaded value always wins over a simultaneous tick. A second property requires that a tick without a load advances the count by exactly one.

// File: rtl/rtc_serial_pkg.sv
package rtc_serial_pkg;

    localparam int SEC_W_D   = 32;
    localparam int FRAC_W_D  = 8;
    localparam int PRESC_W_D = 7;
    localparam int CMD_W     = 8;
    localparam int CTRL_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR_TIME,
        ST_WR_CTRL,
        ST_RD_TIME,
        ST_RD_CTRL,
        ST_SKIP
    } ser_state_t;

endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= d[g];
                stab_q <= meta_q;
            end
        end
        assign q[g] = stab_q;
    end

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
    parameter  int SEC_W   = 32,
    parameter  int FRAC_W  = 8,
    parameter  int PRESC_W = 7,
    localparam int TW      = SEC_W + FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_rise,
    input  logic          run_en,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] count,
    output logic          tick
);

    logic [SEC_W-1:0]   sec_q;
    logic [FRAC_W-1:0]  frac_q;
    logic [PRESC_W-1:0] presc_q;
    logic               presc_full;

    assign presc_full = &presc_q;
    assign tick       = run_en && ref_rise && presc_full;
    assign count      = {sec_q, frac_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q   <= '0;
            frac_q  <= '0;
            presc_q <= '0;
        end else if (load) begin
            // a load takes priority over a tick in the same cycle
            sec_q   <= load_val[TW-1:FRAC_W];
            frac_q  <= load_val[FRAC_W-1:0];
            presc_q <= '0;
        end else if (run_en && ref_rise) begin
            presc_q <= presc_q + PRESC_W'(1);
            if (presc_full) begin
                frac_q <= frac_q + FRAC_W'(1);
                if (&frac_q) begin
                    sec_q <= sec_q + SEC_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rtc_serial_fsm.sv
module rtc_serial_fsm
    import rtc_serial_pkg::*;
#(
    parameter  int         SEC_W     = 32,
    parameter  int         FRAC_W    = 8,
    parameter  logic [6:0] ADDR_TIME = 7'h01,
    parameter  logic [6:0] ADDR_CTRL = 7'h02,
    localparam int         TW        = SEC_W + FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          mosi_s,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic [TW-1:0] count,
    output logic          load,
    output logic [TW-1:0] load_val,
    output logic          run_en,
    output logic          wr_en,
    output logic          miso,
    output ser_state_t    state
);

    localparam int CNT_W = $clog2(TW + 1);

    ser_state_t      state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [TW-1:0]   sh_in_q;
    logic [TW-1:0]   sh_out_q;
    logic [TW-1:0]   sh_next;
    logic            miso_q;
    logic            run_q;
    logic            we_q;
    logic            load_q;
    logic [TW-1:0]   load_val_q;
    logic            cmd_last;
    logic            time_last;
    logic            ctrl_last;
    logic            cmd_rd;
    logic [6:0]      cmd_addr;
    logic [CTRL_W-1:0] ctrl_byte;

    assign sh_next   = {sh_in_q[TW-2:0], mosi_s};
    assign cmd_rd    = sh_next[CMD_W-1];
    assign cmd_addr  = sh_next[CMD_W-2:0];
    assign cmd_last  = sclk_rise && (bit_cnt_q == CNT_W'(CMD_W - 1));
    assign time_last = sclk_rise && (bit_cnt_q == CNT_W'(TW - 1));
    assign ctrl_last = sclk_rise && (bit_cnt_q == CNT_W'(CTRL_W - 1));
    assign ctrl_byte = {{(CTRL_W-2){1'b0}}, we_q, run_q};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_n_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_CMD;
                ST_CMD: begin
                    if (cmd_last) begin
                        if (cmd_addr == ADDR_TIME) begin
                            state_d = cmd_rd ? ST_RD_TIME : ST_WR_TIME;
                        end else if (cmd_addr == ADDR_CTRL) begin
                            state_d = cmd_rd ? ST_RD_CTRL : ST_WR_CTRL;
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                ST_WR_TIME: if (time_last) state_d = ST_SKIP;
                ST_RD_TIME: if (time_last) state_d = ST_SKIP;
                ST_WR_CTRL: if (ctrl_last) state_d = ST_SKIP;
                ST_RD_CTRL: if (ctrl_last) state_d = ST_SKIP;
                ST_SKIP:    state_d = ST_SKIP;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            sh_in_q    <= '0;
            sh_out_q   <= '0;
            miso_q     <= 1'b0;
            run_q      <= 1'b0;
            we_q       <= 1'b0;
            load_q     <= 1'b0;
            load_val_q <= '0;
        end else begin
            load_q <= 1'b0;

            if (state_d != state_q) begin
                bit_cnt_q <= '0;
            end else if (sclk_rise) begin
                bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            end

            if (sclk_rise && (state_q inside {ST_CMD, ST_WR_TIME, ST_WR_CTRL})) begin
                sh_in_q <= sh_next;
            end

            // snapshot captured as the command byte completes
            if (state_q == ST_CMD && cmd_last && cmd_rd) begin
                if (cmd_addr == ADDR_TIME) begin
                    sh_out_q <= count;
                end else if (cmd_addr == ADDR_CTRL) begin
                    sh_out_q <= {ctrl_byte, {(TW-CTRL_W){1'b0}}};
                end
            end else if (sclk_fall && (state_q inside {ST_RD_TIME, ST_RD_CTRL})) begin
                miso_q   <= sh_out_q[TW-1];
                sh_out_q <= {sh_out_q[TW-2:0], 1'b0};
            end

            if (state_q == ST_IDLE) begin
                miso_q <= 1'b0;
            end

            if (state_q == ST_WR_TIME && time_last && !cs_n_s && we_q) begin
                load_q     <= 1'b1;
                load_val_q <= sh_next;
            end

            if (state_q == ST_WR_CTRL && ctrl_last && !cs_n_s) begin
                run_q <= sh_next[0];
                we_q  <= sh_next[1];
            end
        end
    end

    assign load     = load_q;
    assign load_val = load_val_q;
    assign run_en   = run_q;
    assign wr_en    = we_q;
    assign miso     = miso_q;
    assign state    = state_q;

endmodule

// File: rtl/rtc_serial_timer.sv
module rtc_serial_timer
    import rtc_serial_pkg::*;
#(
    parameter  int         SEC_W     = SEC_W_D,
    parameter  int         FRAC_W    = FRAC_W_D,
    parameter  int         PRESC_W   = PRESC_W_D,
    parameter  logic [6:0] ADDR_TIME = 7'h01,
    parameter  logic [6:0] ADDR_CTRL = 7'h02
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso
);

    localparam int TIME_W = SEC_W + FRAC_W;

    logic [3:0]        sync_q;
    logic              ref_s, cs_n_s, sclk_s, mosi_s;
    logic              ref_d, sclk_d;
    logic              ref_rise, sclk_rise, sclk_fall;
    logic              load_w, run_w, we_w, tick_w;
    logic [TIME_W-1:0] load_val_w, count_w;
    ser_state_t        state_w;

    rtc_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ref_clk, cs_n, sclk, mosi}),
        .q     (sync_q)
    );

    assign {ref_s, cs_n_s, sclk_s, mosi_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_d  <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            ref_d  <= ref_s;
            sclk_d <= sclk_s;
        end
    end

    assign ref_rise  = ref_s & ~ref_d;
    assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
    assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;

    rtc_time_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .PRESC_W(PRESC_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (ref_rise),
        .run_en   (run_w),
        .load     (load_w),
        .load_val (load_val_w),
        .count    (count_w),
        .tick     (tick_w)
    );

    rtc_serial_fsm #(
        .SEC_W     (SEC_W),
        .FRAC_W    (FRAC_W),
        .ADDR_TIME (ADDR_TIME),
        .ADDR_CTRL (ADDR_CTRL)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .mosi_s    (mosi_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .count     (count_w),
        .load      (load_w),
        .load_val  (load_val_w),
        .run_en    (run_w),
        .wr_en     (we_w),
        .miso      (miso),
        .state     (state_w)
    );

endmodule

// File: rtl/rtc_serial_timer_chk.sv
module rtc_serial_timer_chk
    import rtc_serial_pkg::*;
#(
    parameter int TW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic [TW-1:0] load_val,
    input logic [TW-1:0] count,
    input logic          run_en,
    input logic          wr_en,
    input logic          tick,
    input ser_state_t    state,
    input logic          miso
);

    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));

    p_load_needs_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> wr_en);

    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load) |=> $stable(count));

    p_tick_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> count == $past(count) + TW'(1));

    p_tick_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run_en);

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> !miso);

endmodule

bind rtc_serial_timer rtc_serial_timer_chk #(.TW(TIME_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_w),
    .load_val (load_val_w),
    .count    (count_w),
    .run_en   (run_w),
    .wr_en    (we_w),
    .tick     (tick_w),
    .state    (state_w),
    .miso     (miso)
);

// File: tb/tb_rtc_serial_timer.sv
module tb_rtc_serial_timer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int idle_cnt = 0;

    logic [39:0] m_count = '0;
    int          m_presc = 0;
    bit          m_run = 1'b0;
    bit          m_we = 1'b0;

    always #5 clk = ~clk;

    rtc_serial_timer dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_clk (ref_clk),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .miso    (miso)
    );

    task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-clock comparison: data out must be quiet while deselected (R9)
    always @(negedge clk) begin
        if (!rst_n || !cs_n) idle_cnt <= 0;
        else idle_cnt <= idle_cnt + 1;
        if (rst_n && idle_cnt >= 6 && !done) check(miso == 1'b0, "R9 idle miso", {39'd0, miso}, 40'd0);
    end

    task automatic ref_edges(input int n);
        for (int i = 0; i < n; i++) begin
            ref_clk = 1'b1;
            if (m_run) begin
                m_presc++;
                if (m_presc == 128) begin
                    m_presc = 0;
                    m_count = m_count + 40'd1;
                end
            end
            clk_n(4);
            ref_clk = 1'b0;
            clk_n(4);
        end
    endtask

    task automatic xfer(input logic [7:0] cmd, input logic [39:0] data, input int nbits, output logic [39:0] rd);
        rd = '0;
        cs_n = 1'b0;
        clk_n(8);
        for (int i = 0; i < 8 + nbits; i++) begin
            mosi = (i < 8) ? cmd[7-i] : data[39-(i-8)];
            clk_n(8);
            sclk = 1'b1;
            if (i >= 8) rd = {rd[38:0], miso};
            clk_n(8);
            sclk = 1'b0;
        end
        clk_n(8);
        cs_n = 1'b1;
        mosi = 1'b0;
        clk_n(12);
    endtask

    task automatic wr_ctrl(input bit run, input bit we);
        logic [39:0] d;
        xfer(8'h02, {6'd0, we, run, 32'd0}, 8, d);
        m_run = run;
        m_we = we;
    endtask

    task automatic wr_time(input logic [39:0] v, input int nbits);
        logic [39:0] d;
        xfer(8'h01, v, nbits, d);
        if (nbits == 40 && m_we) begin
            m_count = v;
            m_presc = 0;
        end
    endtask

    task automatic chk_time(input string req);
        logic [39:0] v;
        xfer(8'h81, 40'd0, 40, v);
        check(v == m_count, req, v, m_count);
    endtask

    task automatic chk_ctrl(input string req);
        logic [39:0] v;
        logic [39:0] exp;
        xfer(8'h82, 40'd0, 8, v);
        exp = {32'd0, 6'd0, m_we, m_run};
        check(v == exp, req, v, exp);
    endtask

    initial begin
        logic [39:0] v;
        logic [39:0] exp;
        clk_n(5);
        rst_n = 1'b1;
        clk_n(10);

        // R1: reset state
        check(miso == 1'b0, "R1 miso after reset", {39'd0, miso}, 40'd0);
        chk_ctrl("R1 control after reset");
        chk_time("R1 count after reset");

        // R4: stopped counter ignores reference edges
        ref_edges(300);
        chk_time("R4 hold while stopped");

        // R7: full write without write enable is discarded
        wr_time(40'h12_3456_7890, 40);
        chk_time("R7 write without enable");

        // R12 / R6: enable writes, then load a value
        wr_ctrl(1'b0, 1'b1);
        chk_ctrl("R12 control readback we");
        wr_time(40'h00_0000_0AFE, 40);
        chk_time("R6 full write loads");

        // R8: aborted write
        wr_time(40'hFF_FFFF_FFFF, 20);
        chk_time("R8 aborted write unchanged");

        // R2: 127 edges no step, 128th steps
        wr_ctrl(1'b1, 1'b1);
        chk_ctrl("R12 control readback run+we");
        ref_edges(127);
        chk_time("R2 no step before 128 edges");
        ref_edges(1);
        chk_time("R2 step on 128th edge");

        // R3: fraction carry into seconds
        ref_edges(128);
        chk_time("R3 fraction carry");
        wr_time(40'hFF_FFFF_FFFF, 40);
        ref_edges(128);
        chk_time("R3 full wrap to zero");

        // R6: prescaler cleared by load
        ref_edges(50);
        wr_time(40'h00_0000_1234, 40);
        ref_edges(127);
        chk_time("R6 prescaler cleared by load");
        ref_edges(1);
        chk_time("R6 step 128 edges after load");

        // R5: unknown address ignored
        xfer(8'h05, 40'hFF_FFFF_FFFF, 40, v);
        xfer(8'h85, 40'd0, 40, v);
        check(v == 40'd0, "R5 unknown read zeros", v, 40'd0);
        chk_time("R5 unknown write no effect");
        xfer(8'h03, 40'h00_0000_0000, 8, v);
        chk_ctrl("R5 unknown write keeps control");

        // R10: early-ended read
        wr_time(40'hA5_C3F0_1E2D, 40);
        xfer(8'h81, 40'd0, 12, v);
        exp = {28'd0, m_count[39:28]};
        check(v == exp, "R10 partial read bits", v, exp);
        chk_time("R10 read after abort");

        // R9 / R11: tick with carry lands during a read burst
        wr_time(40'h00_0000_77FF, 40);
        ref_edges(127);
        exp = m_count;
        fork
            xfer(8'h81, 40'd0, 40, v);
            begin
                clk_n(200);
                ref_edges(1);
            end
        join
        check(v == exp, "R9 snapshot during tick", v, exp);
        chk_time("R11 tick during read counted");

        // R4 / R12: stop counter, clear write enable
        wr_ctrl(1'b0, 1'b0);
        chk_ctrl("R12 control cleared");
        ref_edges(200);
        chk_time("R4 hold after stop");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule